// File: doc/BRIEF.md
# Real-Time Clock Register Access Core with Time Snapshot

This block sits between the byte-level engine of a two-wire serial real-time clock and its register contents. The engine reports four byte events: a bus START, a register address received, a data byte received, and a data byte handed to the host. The block keeps a register pointer over a 19-byte space (00h to 12h). Each data byte written or read advances the pointer, and past 12h it wraps back to 00h, so one burst can cover the whole map.

The seven time bytes (seconds through year) come from an external counter on a parallel bus. Host reads of those bytes never see the live bus. They see a snapshot that is latched on every START and every time the pointer wraps to 00h, so a multibyte read returns one consistent instant even if the counter rolls over during the burst. A host write to a time byte goes out to the counter as a load strobe, which also clears its sub-second prescaler.

Alarm, control, status and aging-offset bytes are held inside the block. Reserved bits of these bytes are masked on write. The temperature bytes are read-only and come from an input bus.

Top module: `rtc_reg_access`

## Requirements
- R1: The pointer is 00h after reset. An address strobe with a value from 00h to 12h loads the pointer. An address value above 12h leaves the pointer unchanged.
- R2: Each accepted data write or data read advances the pointer by one. Advancing from 12h gives 00h.
- R3: A START strobe copies the live time bytes into the snapshot, with reserved bits cleared. It does not move the pointer.
- R4: Advancing the pointer from 12h to 00h also copies the live time bytes into the snapshot, in the same edge.
- R5: Reads at 00h–06h return the snapshot. The snapshot stays unchanged while no capture event occurs, even if the live bus changes.
- R6: A data write at 00h–06h raises time_wr_o and presc_clr_o in that same cycle. In that cycle, time_idx_o equals the address and time_wdata_o equals the byte with reserved bits cleared. The snapshot is not changed by the write.
- R7: Bytes 07h–10h read back as last written, ANDed with a mask. The mask is E7h at 0Eh, 8Bh at 0Fh and FFh elsewhere. ctrl_o, stat_o and aging_o show 0Eh, 0Fh and 10h.
- R8: A read at 11h returns temp_i[9:2]. A read at 12h returns {temp_i[1:0], 6'b0}. Writes to 11h and 12h change nothing.
- R9: Time reserved bits read as zero. The byte masks for 00h to 06h are 7Fh, 7Fh, 7Fh, 07h, 3Fh, 9Fh and FFh.
- R10: Only one strobe acts per cycle. The priority order is START, then address, then data write, then data read. A data write in the same cycle as START raises no time_wr_o and does not move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Bus START seen |
| addr_wr_i | input | 1 | Register address byte received |
| addr_i | input | 5 | Register address |
| data_wr_i | input | 1 | Data byte received |
| wdata_i | input | 8 | Received data byte |
| data_rd_i | input | 1 | Data byte taken by host |
| rdata_o | output | 8 | Byte at current pointer |
| time_live_i | input | 56 | Live time bytes, byte n at bits 8n+7:8n |
| temp_i | input | 10 | Signed temperature, quarter-degree LSB |
| time_wr_o | output | 1 | Load strobe to time counter |
| time_idx_o | output | 3 | Time byte being loaded |
| time_wdata_o | output | 8 | Masked load value |
| presc_clr_o | output | 1 | Clear sub-second prescaler |
| ctrl_o | output | 8 | Control byte |
| stat_o | output | 8 | Status byte |
| aging_o | output | 8 | Aging offset byte |

## Verification
The bench attacks the wrap at 12h. A design that rolls over at a power-of-two boundary would return wrong bytes after 12h. A design that skips the wrap capture would return the stale time at 00h. A burst read is done while the live bus changes on every cycle, so a design that reads the live bus, or captures on every access, returns bytes from mixed instants. Out-of-range addresses, writes to the read-only temperature bytes, and a data write that collides with START are driven on purpose. A pointer that takes the bad address, or a write that leaks through, shows up in the next read or as a spurious load strobe.

// File: rtl/rtc_reg_pkg.sv
package rtc_reg_pkg;
  localparam int REG_LAST  = 18;
  localparam int TIME_BYTES = 7;
  localparam int CFG_FIRST = 7;
  localparam int CFG_LAST  = 16;
  localparam int TEMP_BITS = 10;

  // writable / readable bits per register address
  function automatic logic [7:0] reg_mask(input int unsigned a);
    case (a)
      0, 1, 2: reg_mask = 8'h7F;
      3:       reg_mask = 8'h07;
      4:       reg_mask = 8'h3F;
      5:       reg_mask = 8'h9F;
      14:      reg_mask = 8'hE7;
      15:      reg_mask = 8'h8B;
      default: reg_mask = 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/rtc_ptr.sv
module rtc_ptr #(
  parameter int AW   = 5,
  parameter int LAST = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic [AW-1:0] set_val_i,
  input  logic          step_i,
  output logic [AW-1:0] ptr_o,
  output logic          wrap_o
);
  localparam logic [AW-1:0] LAST_A = AW'(LAST);

  logic [AW-1:0] ptr_q;

  assign wrap_o = step_i && (ptr_q == LAST_A);
  assign ptr_o  = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (set_i)  ptr_q <= set_val_i;
    else if (wrap_o) ptr_q <= '0;
    else if (step_i) ptr_q <= ptr_q + AW'(1);
  end
endmodule

// File: rtl/rtc_snap.sv
module rtc_snap
  import rtc_reg_pkg::*;
#(
  parameter int NB = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cap_i,
  input  logic [NB*8-1:0] live_i,
  output logic [NB*8-1:0] snap_o
);
  for (genvar g = 0; g < NB; g++) begin : g_byte
    localparam logic [7:0] MSK = reg_mask(g);
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    q <= '0;
      else if (cap_i) q <= live_i[g*8 +: 8] & MSK;
    end
    assign snap_o[g*8 +: 8] = q;
  end
endmodule

// File: rtl/rtc_cfg_regs.sv
module rtc_cfg_regs
  import rtc_reg_pkg::*;
#(
  parameter int AW = 5,
  parameter int LO = 7,
  parameter int HI = 16,
  localparam int N = HI - LO + 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [7:0]     wdata_i,
  output logic [N*8-1:0] regs_o
);
  for (genvar g = 0; g < N; g++) begin : g_reg
    localparam logic [AW-1:0] A   = AW'(LO + g);
    localparam logic [7:0]    MSK = reg_mask(LO + g);
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   q <= '0;
      else if (we_i && addr_i == A)  q <= wdata_i & MSK;
    end
    assign regs_o[g*8 +: 8] = q;
  end
endmodule

// File: rtl/rtc_reg_access.sv
module rtc_reg_access
  import rtc_reg_pkg::*;
#(
  parameter int LAST_ADDR = REG_LAST,
  parameter int TIME_N    = TIME_BYTES,
  parameter int CFG_LO    = CFG_FIRST,
  parameter int CFG_HI    = CFG_LAST,
  parameter int TEMP_W    = TEMP_BITS,
  localparam int AW       = $clog2(LAST_ADDR + 1),
  localparam int IW       = $clog2(TIME_N)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                addr_wr_i,
  input  logic [AW-1:0]       addr_i,
  input  logic                data_wr_i,
  input  logic [7:0]          wdata_i,
  input  logic                data_rd_i,
  output logic [7:0]          rdata_o,
  input  logic [TIME_N*8-1:0] time_live_i,
  input  logic [TEMP_W-1:0]   temp_i,
  output logic                time_wr_o,
  output logic [IW-1:0]       time_idx_o,
  output logic [7:0]          time_wdata_o,
  output logic                presc_clr_o,
  output logic [7:0]          ctrl_o,
  output logic [7:0]          stat_o,
  output logic [7:0]          aging_o
);
  localparam int CFG_N = CFG_HI - CFG_LO + 1;
  localparam logic [AW-1:0] LAST_A = AW'(LAST_ADDR);
  localparam logic [AW-1:0] TIME_A = AW'(TIME_N);
  localparam logic [AW-1:0] CLO_A  = AW'(CFG_LO);
  localparam logic [AW-1:0] CHI_A  = AW'(CFG_HI);
  localparam logic [AW-1:0] TMSB_A = AW'(CFG_HI + 1);
  localparam logic [AW-1:0] TLSB_A = AW'(CFG_HI + 2);

  logic          do_set, do_wr, do_rd, step, wrap, cap;
  logic [AW-1:0] ptr;
  logic [TIME_N*8-1:0] snap;
  logic [CFG_N*8-1:0]  cfg;
  logic [7:0]          wmask;

  // single event per cycle, START first
  assign do_set = !start_i && addr_wr_i && (addr_i <= LAST_A);
  assign do_wr  = !start_i && !addr_wr_i && data_wr_i;
  assign do_rd  = !start_i && !addr_wr_i && !data_wr_i && data_rd_i;
  assign step   = do_wr || do_rd;
  assign cap    = start_i || wrap;

  rtc_ptr #(.AW(AW), .LAST(LAST_ADDR)) u_ptr (
    .clk_i, .rst_ni,
    .set_i(do_set), .set_val_i(addr_i), .step_i(step),
    .ptr_o(ptr), .wrap_o(wrap)
  );

  rtc_snap #(.NB(TIME_N)) u_snap (
    .clk_i, .rst_ni, .cap_i(cap), .live_i(time_live_i), .snap_o(snap)
  );

  rtc_cfg_regs #(.AW(AW), .LO(CFG_LO), .HI(CFG_HI)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(do_wr && ptr >= CLO_A && ptr <= CHI_A),
    .addr_i(ptr), .wdata_i(wdata_i), .regs_o(cfg)
  );

  always_comb begin
    wmask = 8'hFF;
    for (int i = 0; i < TIME_N; i++)
      if (ptr == AW'(i)) wmask = reg_mask(i);
  end

  assign time_wr_o    = do_wr && (ptr < TIME_A);
  assign time_idx_o   = ptr[IW-1:0];
  assign time_wdata_o = wdata_i & wmask;
  assign presc_clr_o  = time_wr_o;

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < TIME_N; i++)
      if (ptr == AW'(i)) rdata_o = snap[i*8 +: 8];
    for (int i = 0; i < CFG_N; i++)
      if (ptr == AW'(CFG_LO + i)) rdata_o = cfg[i*8 +: 8];
    if (ptr == TMSB_A) rdata_o = temp_i[TEMP_W-1 -: 8];
    if (ptr == TLSB_A) rdata_o = {temp_i[TEMP_W-9:0], {(16-TEMP_W){1'b0}}};
  end

  assign ctrl_o  = cfg[(CFG_HI-2-CFG_LO)*8 +: 8];
  assign stat_o  = cfg[(CFG_HI-1-CFG_LO)*8 +: 8];
  assign aging_o = cfg[(CFG_HI-CFG_LO)*8 +: 8];
endmodule

// File: rtl/rtc_reg_access_chk.sv
module rtc_reg_access_chk
  import rtc_reg_pkg::*;
#(
  parameter int AW = 5,
  parameter int LAST_ADDR = 18,
  parameter int TIME_N = 7
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic                addr_wr_i,
  input logic [AW-1:0]       addr_i,
  input logic                data_wr_i,
  input logic                data_rd_i,
  input logic [TIME_N*8-1:0] time_live_i,
  input logic                time_wr_o,
  input logic [AW-1:0]       ptr,
  input logic [TIME_N*8-1:0] snap
);
  localparam logic [AW-1:0] LAST_A = AW'(LAST_ADDR);
  logic [TIME_N*8-1:0] live_m;
  logic                adv, at_end;

  always_comb
    for (int i = 0; i < TIME_N; i++) live_m[i*8 +: 8] = time_live_i[i*8 +: 8] & reg_mask(i);

  assign adv    = !start_i && !addr_wr_i && (data_wr_i || data_rd_i);
  assign at_end = adv && (ptr == LAST_A);

  p_ptr_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni) ptr <= LAST_A);
  p_bad_addr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && addr_wr_i && addr_i > LAST_A) |=> ptr == $past(ptr));
  p_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni) at_end |=> ptr == '0);
  p_cap_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> snap == $past(live_m));
  p_cap_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_end |=> snap == $past(live_m));
  p_snap_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !at_end) |=> $stable(snap));
  p_time_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_wr_o |=> ptr == $past(ptr) + AW'(1));
  p_start_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> ptr == $past(ptr));
endmodule

bind rtc_reg_access rtc_reg_access_chk #(.AW(AW), .LAST_ADDR(LAST_ADDR), .TIME_N(TIME_N)) u_chk (
  .clk_i, .rst_ni, .start_i, .addr_wr_i, .addr_i, .data_wr_i, .data_rd_i,
  .time_live_i, .time_wr_o, .ptr(ptr), .snap(snap)
);

// File: tb/sim_rtc_reg_access.sv
module sim_rtc_reg_access;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        start = 0, addr_wr = 0, data_wr = 0, data_rd = 0;
  logic [4:0]  addr = 0;
  logic [7:0]  wdata = 0, rdata;
  logic [55:0] live = 0;
  logic [9:0]  temp = 0;
  logic        time_wr, presc_clr;
  logic [2:0]  time_idx;
  logic [7:0]  time_wdata, ctrl, stat, aging;

  int checks = 0, fails = 0;
  int ptr_m = 0;
  logic [7:0] snap_m [7];
  logic [7:0] regs_m [19];

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_reg_access u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_wr_i(addr_wr), .addr_i(addr),
    .data_wr_i(data_wr), .wdata_i(wdata), .data_rd_i(data_rd), .rdata_o(rdata),
    .time_live_i(live), .temp_i(temp), .time_wr_o(time_wr), .time_idx_o(time_idx),
    .time_wdata_o(time_wdata), .presc_clr_o(presc_clr), .ctrl_o(ctrl), .stat_o(stat),
    .aging_o(aging)
  );

  function automatic logic [7:0] m_of(int a);
    logic [7:0] t [7] = '{8'h7F, 8'h7F, 8'h7F, 8'h07, 8'h3F, 8'h9F, 8'hFF};
    if (a < 7) return t[a];
    if (a == 14) return 8'hE7;
    if (a == 15) return 8'h8B;
    return 8'hFF;
  endfunction

  function automatic logic [7:0] exp_rd(int p);
    if (p < 7) return snap_m[p];
    if (p <= 16) return regs_m[p];
    if (p == 17) return temp[9:2];
    return {temp[1:0], 6'b0};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // kind: 0 start, 1 addr, 2 write, 3 read, 4 start+write
  task automatic op(input int kind, input logic [7:0] val);
    @(negedge clk);
    live = {$urandom, $urandom};
    live = live[55:0];
    temp = 10'($urandom);
    start   = (kind == 0 || kind == 4);
    addr_wr = (kind == 1);
    addr    = val[4:0];
    data_wr = (kind == 2 || kind == 4);
    wdata   = val;
    data_rd = (kind == 3);
    #1;
    if (kind == 3) begin
      if (ptr_m < 7)       chk(rdata == exp_rd(ptr_m), "R5 R9 time read", rdata, exp_rd(ptr_m));
      else if (ptr_m < 17) chk(rdata == exp_rd(ptr_m), "R7 cfg read", rdata, exp_rd(ptr_m));
      else                 chk(rdata == exp_rd(ptr_m), "R8 temp read", rdata, exp_rd(ptr_m));
    end
    if (kind == 2 && ptr_m < 7) begin
      chk(time_wr && presc_clr, "R6 load strobe", {time_wr, presc_clr}, 3);
      chk(time_idx == 3'(ptr_m), "R6 load index", time_idx, ptr_m);
      chk(time_wdata == (val & m_of(ptr_m)), "R6 R9 load data", time_wdata, val & m_of(ptr_m));
    end else if (kind != 3) begin
      chk(!time_wr && !presc_clr, "R6 R10 no load strobe", {time_wr, presc_clr}, 0);
    end
    @(posedge clk);
    #1;
    start = 0; addr_wr = 0; data_wr = 0; data_rd = 0;
    case (kind)
      0, 4: for (int i = 0; i < 7; i++) snap_m[i] = live[i*8 +: 8] & m_of(i);
      1: if (int'(val[4:0]) <= 18) ptr_m = int'(val[4:0]);
      default: begin
        if (kind == 2 && ptr_m >= 7 && ptr_m <= 16) regs_m[ptr_m] = val & m_of(ptr_m);
        if (ptr_m == 18) begin
          ptr_m = 0;
          for (int i = 0; i < 7; i++) snap_m[i] = live[i*8 +: 8] & m_of(i);
        end else ptr_m++;
      end
    endcase
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!time_wr && !presc_clr, "R1 idle after reset", time_wr, 0);
    // R1: pointer starts at 00h
    op(2, 8'hFF);
    op(1, 8'd7);
    for (int a = 7; a <= 18; a++) op(2, (a == 14 || a == 15) ? 8'hFF : 8'($urandom));
    chk(ptr_m == 0, "R2 model wrap", ptr_m, 0);
    op(1, 8'd14);
    op(3, 0); op(3, 0); op(3, 0);
    @(negedge clk);
    chk(ctrl == regs_m[14] && stat == regs_m[15] && aging == regs_m[16], "R7 side outputs",
        {ctrl, stat, aging}, {regs_m[14], regs_m[15], regs_m[16]});
    // R3 start capture, then full burst with wrap (R2, R4)
    op(0, 0);
    op(1, 8'd0);
    for (int i = 0; i < 19; i++) op(3, 0);
    op(3, 0);
    // R1 out-of-range address ignored
    op(1, 8'd3);
    op(1, 8'd25);
    op(3, 0);
    op(1, 8'd31);
    op(3, 0);
    // R8 temperature writes ignored
    op(1, 8'd17);
    op(2, 8'h5A); op(2, 8'hA5);
    op(1, 8'd17);
    op(3, 0); op(3, 0);
    // R10 start beats write
    op(1, 8'd2);
    op(4, 8'h33);
    op(3, 0);
    // R6 write to time bytes leaves snapshot alone
    op(1, 8'd0);
    op(2, 8'h12); op(2, 8'h34);
    op(1, 8'd0);
    op(3, 0); op(3, 0);
    for (int n = 0; n < 800; n++) begin
      int k = int'($urandom % 10);
      if (k == 0)      op(0, 0);
      else if (k == 1) op(1, 8'($urandom % 24));
      else if (k == 2) op(4, 8'($urandom));
      else if (k < 6)  op(2, 8'($urandom));
      else             op(3, 0);
    end
    @(negedge clk);
    chk(ctrl == regs_m[14] && stat == regs_m[15] && aging == regs_m[16], "R7 final outputs",
        {ctrl, stat, aging}, {regs_m[14], regs_m[15], regs_m[16]});
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule